// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block keeps two small per-CPU pending vectors for a four-processor node: one for inter-processor interrupts and one for interval-timer interrupts. Each pending bit drives that CPU's interrupt line directly. Software raises and retires inter-processor interrupts and retires timer interrupts through a register interface. An external tick from the interval timer marks every CPU's timer interrupt pending.

The control register packs three CPU-mask fields. One write to it can request, clear and retire interrupts together. Three further registers take a plain CPU mask in the low bits of the written word. The block flags writes that carry no useful content as errors. It warns on redundant requests and clears with a single-cycle pulse. A read returns the pending vectors, or the number of the CPU that issues the read.

Top module: `ipi_tmr_irq_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both pending vectors clear to zero. After reset, `ipi_irq`, `tmr_irq`, `rd_valid`, `warn_pulse` and `err_pulse` are all zero.
- R2: A write to the control register (`reg_sel` = 0) uses bits 15:12 as a mask of CPUs whose inter-processor interrupt is requested, bits 11:8 as a mask of CPUs whose inter-processor interrupt is cleared, and bits 7:4 as a mask of CPUs whose timer interrupt is cleared. The request is applied before the clear, so a CPU named in both fields ends with no pending inter-processor interrupt and raises no warning.
- R3: A control write with bit 28 set is accepted as an error-status acknowledge. It changes no state and raises neither pulse.
- R4: A control write with bits 15:4 and bit 28 all zero raises `err_pulse` in the cycle the write is presented and changes no state.
- R5: Requesting an inter-processor interrupt for a CPU whose interrupt is already pending leaves that bit unchanged and raises `warn_pulse` in the write cycle.
- R6: Clearing an inter-processor interrupt for a CPU with none pending leaves the vector unchanged and raises `warn_pulse` in the write cycle.
- R7: A write to `reg_sel` = 3 requests, to `reg_sel` = 1 clears the inter-processor interrupts, and to `reg_sel` = 2 clears the timer interrupts, of the CPUs set in bits 3:0 of the written word. If those bits are zero, `err_pulse` is raised and no state changes.
- R8: A cycle with `timer_tick` high sets the pending timer bit of every CPU. A timer clear in the same cycle takes effect after the tick, so the named CPUs end with no pending timer interrupt.
- R9: A timer clear affects only CPUs that are both named in the mask and currently pending. Naming a CPU that is not pending raises no warning.
- R10: A read (`rd_en`) sets `rd_valid` and `rdata` on the next edge. Selector 0 returns `req_cpu` in bits 1:0 with zeros above. Selector 1 returns the inter-processor vector in bits 3:0. Selector 2 returns the timer vector in bits 3:0. Selector 3 returns zero.
- R11: `ipi_irq` and `tmr_irq` are the pending vectors, bit n for CPU n. They change only on the clock edge that accepts a write or a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| reg_sel | input | 2 | Register selector: 0 control, 1 IPI vector/clear, 2 timer vector/clear, 3 IPI request |
| wdata | input | 64 | Write data |
| req_cpu | input | 2 | Number of the CPU issuing the access |
| timer_tick | input | 1 | Interval-timer tick, posts a timer interrupt to all CPUs |
| rdata | output | 64 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| ipi_irq | output | 4 | Per-CPU inter-processor interrupt line |
| tmr_irq | output | 4 | Per-CPU timer interrupt line |
| warn_pulse | output | 1 | Redundant request or clear in the current write |
| err_pulse | output | 1 | Unsupported or empty-mask write in the current write |

## Verification
The assertions check four things on every cycle. The pulses appear only together with a write. The interrupt lines hold steady without a write or a tick. A tick without a write fills the timer vector. A read returns its data one cycle later, and a control-register read returns the issuing CPU's number. Only the bench scenarios can show that the field positions decode correctly, that a request comes before a clear in the same write, that a clear beats a same-cycle tick, and that each redundant operation leaves the right bits alone.

// File: rtl/ipi_tmr_pkg.sv
// Shared definitions for the interrupt controller: register selectors and
// the bit positions of the control-register fields.
package ipi_tmr_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_IPI     = 2'd1,
        SEL_TMR     = 2'd2,
        SEL_IPI_REQ = 2'd3
    } reg_sel_e;

    localparam int FIELD_W    = 4;   // width of each CPU-mask field
    localparam int REQ_LSB    = 12;  // IPI request mask
    localparam int CLR_LSB    = 8;   // IPI clear mask
    localparam int TCLR_LSB   = 4;   // timer clear mask
    localparam int ACK_BIT    = 28;  // error-status acknowledge

endpackage

// File: rtl/ipi_wr_decode.sv
// Write decoder: turns one register write into per-CPU set/clear masks.
// Assumes NUM_CPU <= FIELD_W and DATA_W > ACK_BIT. Masks are zero when
// no write is presented. The error flag is combinational.
module ipi_wr_decode
    import ipi_tmr_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64
) (
    input  logic               wr_en,
    input  logic [1:0]         reg_sel,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_CPU-1:0] ipi_set,
    output logic [NUM_CPU-1:0] ipi_clr,
    output logic [NUM_CPU-1:0] tmr_clr,
    output logic               bad_wr
);

    reg_sel_e           sel;
    logic               ctrl_any;
    logic [NUM_CPU-1:0] low_mask;
    logic               unused_wdata;

    assign sel          = reg_sel_e'(reg_sel);
    assign low_mask     = wdata[NUM_CPU-1:0];
    assign unused_wdata = ^wdata;

    // Any field of the control register carrying content.
    assign ctrl_any = (|wdata[REQ_LSB +: FIELD_W]) | (|wdata[CLR_LSB +: FIELD_W])
                    | (|wdata[TCLR_LSB +: FIELD_W]) | wdata[ACK_BIT];

    // Decode the selected register into masks and the error flag.
    always_comb begin
        ipi_set = '0;
        ipi_clr = '0;
        tmr_clr = '0;
        bad_wr  = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_CTRL: begin
                    ipi_set = wdata[REQ_LSB  +: NUM_CPU];
                    ipi_clr = wdata[CLR_LSB  +: NUM_CPU];
                    tmr_clr = wdata[TCLR_LSB +: NUM_CPU];
                    bad_wr  = !ctrl_any;
                end
                SEL_IPI: begin
                    ipi_clr = low_mask;
                    bad_wr  = (low_mask == '0);
                end
                SEL_TMR: begin
                    tmr_clr = low_mask;
                    bad_wr  = (low_mask == '0);
                end
                SEL_IPI_REQ: begin
                    ipi_set = low_mask;
                    bad_wr  = (low_mask == '0);
                end
                default: bad_wr = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/ipi_pend_vec.sv
// Pending inter-processor interrupt vector. The request is applied first
// and the clear second. A redundant request or clear sets the warning.
module ipi_pend_vec #(
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CPU-1:0] set_mask,
    input  logic [NUM_CPU-1:0] clr_mask,
    output logic [NUM_CPU-1:0] pend,
    output logic               warn
);

    logic [NUM_CPU-1:0] nxt;
    logic [NUM_CPU-1:0] warn_bit;

    // One slice per CPU: next state and redundancy detection.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic after_req;
        assign after_req   = pend[c] | set_mask[c];
        assign nxt[c]      = after_req & ~clr_mask[c];
        assign warn_bit[c] = (set_mask[c] & pend[c]) | (clr_mask[c] & ~after_req);
    end

    assign warn = |warn_bit;

    // Pending-vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= nxt;
    end

endmodule

// File: rtl/tmr_pend_vec.sv
// Pending timer interrupt vector. A tick marks every CPU pending. A clear in
// the same cycle applies after the tick. Only pending bits can be cleared.
module tmr_pend_vec #(
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [NUM_CPU-1:0] clr_mask,
    output logic [NUM_CPU-1:0] pend
);

    logic [NUM_CPU-1:0] after_tick;

    assign after_tick = tick ? {NUM_CPU{1'b1}} : pend;

    // Pending-vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= after_tick & ~clr_mask;
    end

endmodule

// File: rtl/ipi_tmr_irq_ctl.sv
// Top of the inter-processor and timer interrupt controller. It assumes at
// most one write per cycle, and reads return one cycle later. The interrupt
// lines come straight from the pending registers.
module ipi_tmr_irq_ctl
    import ipi_tmr_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         reg_sel,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CPU_W-1:0]   req_cpu,
    input  logic               timer_tick,
    output logic [DATA_W-1:0]  rdata,
    output logic               rd_valid,
    output logic [NUM_CPU-1:0] ipi_irq,
    output logic [NUM_CPU-1:0] tmr_irq,
    output logic               warn_pulse,
    output logic               err_pulse
);

    logic [NUM_CPU-1:0] ipi_set, ipi_clr, tmr_clr;
    logic [NUM_CPU-1:0] ipi_pend, tmr_pend;
    logic [DATA_W-1:0]  rd_mux;
    reg_sel_e           rsel;

    ipi_wr_decode #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_dec (
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wdata   (wdata),
        .ipi_set (ipi_set),
        .ipi_clr (ipi_clr),
        .tmr_clr (tmr_clr),
        .bad_wr  (err_pulse)
    );

    ipi_pend_vec #(.NUM_CPU(NUM_CPU)) u_ipi (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (ipi_set),
        .clr_mask (ipi_clr),
        .pend     (ipi_pend),
        .warn     (warn_pulse)
    );

    tmr_pend_vec #(.NUM_CPU(NUM_CPU)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (timer_tick),
        .clr_mask (tmr_clr),
        .pend     (tmr_pend)
    );

    assign ipi_irq = ipi_pend;
    assign tmr_irq = tmr_pend;
    assign rsel    = reg_sel_e'(reg_sel);

    // Select the read value for the addressed register.
    always_comb begin
        rd_mux = '0;
        unique case (rsel)
            SEL_CTRL:    rd_mux[CPU_W-1:0]   = req_cpu;
            SEL_IPI:     rd_mux[NUM_CPU-1:0] = ipi_pend;
            SEL_TMR:     rd_mux[NUM_CPU-1:0] = tmr_pend;
            SEL_IPI_REQ: rd_mux = '0;
            default:     rd_mux = '0;
        endcase
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rdata    <= '0;
        end else begin
            rd_valid <= rd_en;
            rdata    <= rd_en ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/ipi_tmr_chk.sv
// Property checker for the interrupt controller, attached by bind.
module ipi_tmr_chk #(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64,
    parameter int CPU_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               rd_en,
    input logic [1:0]         reg_sel,
    input logic [CPU_W-1:0]   req_cpu,
    input logic               timer_tick,
    input logic [DATA_W-1:0]  rdata,
    input logic               rd_valid,
    input logic [NUM_CPU-1:0] ipi_irq,
    input logic [NUM_CPU-1:0] tmr_irq,
    input logic               warn_pulse,
    input logic               err_pulse
);

    p_err_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> wr_en);

    p_warn_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        warn_pulse |-> wr_en);

    p_err_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse && !timer_tick |=> $stable(ipi_irq) && $stable(tmr_irq));

    p_ipi_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ipi_irq));

    p_tmr_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_tick |=> ((tmr_irq & ~$past(tmr_irq)) == '0));

    p_tick_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timer_tick && !wr_en |=> (&tmr_irq));

    p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_cpu_id_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (reg_sel == 2'd0) |=>
            (rdata[CPU_W-1:0] == $past(req_cpu)) && (rdata[DATA_W-1:CPU_W] == '0));

endmodule

bind ipi_tmr_irq_ctl ipi_tmr_chk #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W), .CPU_W(CPU_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .reg_sel    (reg_sel),
    .req_cpu    (req_cpu),
    .timer_tick (timer_tick),
    .rdata      (rdata),
    .rd_valid   (rd_valid),
    .ipi_irq    (ipi_irq),
    .tmr_irq    (tmr_irq),
    .warn_pulse (warn_pulse),
    .err_pulse  (err_pulse)
);

// File: tb/sim_ipi_tmr_irq_ctl.sv
// Scoreboard bench. Write tasks check the pulses and vectors. The read
// driver queues expected data, and a monitor compares each response.
module sim_ipi_tmr_irq_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [63:0] wdata = '0;
    logic [1:0]  req_cpu = '0;
    logic        timer_tick = 1'b0;
    logic [63:0] rdata;
    logic        rd_valid;
    logic [3:0]  ipi_irq;
    logic [3:0]  tmr_irq;
    logic        warn_pulse;
    logic        err_pulse;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;  // 125 MHz

    ipi_tmr_irq_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wdata(wdata), .req_cpu(req_cpu),
        .timer_tick(timer_tick), .rdata(rdata), .rd_valid(rd_valid),
        .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
        .warn_pulse(warn_pulse), .err_pulse(err_pulse)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one write (optionally with a tick), check pulses, then vectors.
    task automatic wr(input logic [1:0] sel, input logic [63:0] d, input bit tk,
                      input logic [3:0] e_ipi, input logic [3:0] e_tmr,
                      input bit e_warn, input bit e_err, input string tag);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wdata = d; timer_tick = tk;
        #1;
        chk({tag, " warn"}, {63'b0, warn_pulse}, {63'b0, e_warn});
        chk({tag, " err"},  {63'b0, err_pulse},  {63'b0, e_err});
        @(posedge clk);
        #1;
        wr_en = 1'b0; wdata = '0; timer_tick = 1'b0;
        @(negedge clk);
        chk({tag, " ipi"}, {60'b0, ipi_irq}, {60'b0, e_ipi});
        chk({tag, " tmr"}, {60'b0, tmr_irq}, {60'b0, e_tmr});
    endtask

    task automatic tick(input logic [3:0] e_ipi, input string tag);
        @(negedge clk);
        timer_tick = 1'b1;
        @(posedge clk);
        #1;
        timer_tick = 1'b0;
        @(negedge clk);
        chk({tag, " tmr"}, {60'b0, tmr_irq}, 64'hF);
        chk({tag, " ipi"}, {60'b0, ipi_irq}, {60'b0, e_ipi});
    endtask

    // Read driver: queue the expected value for the monitor.
    task automatic rd(input logic [1:0] sel, input logic [1:0] cpu,
                      input logic [63:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; reg_sel = sel; req_cpu = cpu;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    // Monitor: compare each read response against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected read", rdata, 64'hx);
            end else begin
                automatic logic [63:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, rdata, e);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ipi", {60'b0, ipi_irq}, 64'h0);
        chk("R1 tmr", {60'b0, tmr_irq}, 64'h0);
        chk("R1 pulses", {62'b0, warn_pulse, err_pulse}, 64'h0);
        chk("R1 rd_valid", {63'b0, rd_valid}, 64'h0);
        rd(2'd1, 2'd0, 64'h0, "R1 read ipi vector");

        // R2: request cpus 0,1 through bits 15:12
        wr(2'd0, 64'h3000, 1'b0, 4'b0011, 4'b0000, 1'b0, 1'b0, "R2 ctrl request");
        // R5: redundant request for cpu0
        wr(2'd0, 64'h1000, 1'b0, 4'b0011, 4'b0000, 1'b1, 1'b0, "R5 redundant request");
        // R2: clear cpu1 through bits 11:8
        wr(2'd0, 64'h0200, 1'b0, 4'b0001, 4'b0000, 1'b0, 1'b0, "R2 ctrl clear");
        // R6: clear of non-pending cpu2
        wr(2'd0, 64'h0400, 1'b0, 4'b0001, 4'b0000, 1'b1, 1'b0, "R6 clear idle");
        // R2: request and clear cpu3 together, clear wins, no warning
        wr(2'd0, 64'h8800, 1'b0, 4'b0001, 4'b0000, 1'b0, 1'b0, "R2 request then clear");
        // R3: acknowledge bit only
        wr(2'd0, 64'h1000_0000, 1'b0, 4'b0001, 4'b0000, 1'b0, 1'b0, "R3 ack");
        // R4: empty control writes
        wr(2'd0, 64'h0, 1'b0, 4'b0001, 4'b0000, 1'b0, 1'b1, "R4 zero write");
        wr(2'd0, 64'hFFFF_0000_0000_000F, 1'b0, 4'b0001, 4'b0000, 1'b0, 1'b1, "R4 unused bits");

        // R8: tick fills timer vector
        tick(4'b0001, "R8 tick");
        rd(2'd2, 2'd0, 64'hF, "R10 read timer vector");
        // R2/R9: timer clear cpus 0,2 through bits 7:4
        wr(2'd0, 64'h0050, 1'b0, 4'b0001, 4'b1010, 1'b0, 1'b0, "R9 ctrl timer clear");
        // R9: clear of non-pending timer bits, no warning
        wr(2'd2, 64'h5, 1'b0, 4'b0001, 4'b1010, 1'b0, 1'b0, "R9 clear idle timer");

        // R7: direct registers
        wr(2'd3, 64'hC, 1'b0, 4'b1101, 4'b1010, 1'b0, 1'b0, "R7 direct request");
        wr(2'd3, 64'h1, 1'b0, 4'b1101, 4'b1010, 1'b1, 1'b0, "R7 R5 direct redundant");
        wr(2'd1, 64'h4, 1'b0, 4'b1001, 4'b1010, 1'b0, 1'b0, "R7 direct clear");
        wr(2'd1, 64'h0, 1'b0, 4'b1001, 4'b1010, 1'b0, 1'b1, "R7 zero clear");
        wr(2'd3, 64'hF0, 1'b0, 4'b1001, 4'b1010, 1'b0, 1'b1, "R7 zero low mask");
        wr(2'd2, 64'h0, 1'b0, 4'b1001, 4'b1010, 1'b0, 1'b1, "R7 zero timer clear");
        wr(2'd2, 64'h8, 1'b0, 4'b1001, 4'b0010, 1'b0, 1'b0, "R7 direct timer clear");

        // R8: tick with a same-cycle full timer clear
        wr(2'd0, 64'h00F0, 1'b1, 4'b1001, 4'b0000, 1'b0, 1'b0, "R8 tick and clear");
        wr(2'd0, 64'h0030, 1'b1, 4'b1001, 4'b1100, 1'b0, 1'b0, "R8 tick partial clear");

        // R10: reads
        rd(2'd0, 2'd2, 64'h2, "R10 cpu id 2");
        rd(2'd0, 2'd3, 64'h3, "R10 cpu id 3");
        rd(2'd3, 2'd1, 64'h0, "R10 request reg reads zero");
        rd(2'd1, 2'd0, 64'h9, "R10 read ipi vector");
        rd(2'd2, 2'd1, 64'hC, "R10 R11 read timer vector");

        repeat (3) @(negedge clk);
        chk("R10 all reads answered", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule